// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block lets a clocked system use an external asynchronous static RAM of 32K bytes. The user side offers one request at a time: a request strobe, a write flag, a 15-bit word address and a byte of write data. The block answers each request with a one-cycle completion pulse, and for reads it also presents the fetched byte on a held output register. On the memory side it drives active-low chip select, write strobe and output-enable lines, the address bus, and a data bus that is split into an outgoing byte, a drive-enable flag and an incoming byte.

Each timing interval the memory needs is a whole number of clock cycles. The block computes each count at elaboration from a nanosecond minimum and the clock period, rounding up, with a floor of one cycle. Every strobe leaves a flop. The address is frozen for the whole of each access. The block will not drive the shared bus until the memory has had time to release it after a read. Between requests it drops every select line to the inactive level, so the memory can sit in its low-current standby state.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and whenever `ready` is high, chip select, write strobe and output enable are all high (inactive), `mem_dq_oe` is 0 and `done` is 0.
- R2: A read asserts chip select and output enable low with the write strobe high for RC cycles, where RC = ceil(T_RC_NS / CLK_PERIOD_NS). The incoming byte is captured at the edge that ends that window. `done` rises RC+1 cycles after the accepting edge, with `rdata` equal to the byte last written to that address (0 for an address never written).
- R3: A write holds chip select and the write strobe low, keeps output enable high and drives `mem_dq_o` with `mem_dq_oe` = 1 for WR cycles. WR is the largest of RC, ceil(T_WP_NS/period) and ceil(T_DW_NS/period). `done` rises WR+1 cycles after the accepting edge.
- R4: `mem_addr` does not change on any cycle where chip select stays low from the previous cycle, and never while the write strobe is low.
- R5: Output enable is never low while the write strobe is low. `mem_dq_oe` is 1 only while output enable is high and chip select is low.
- R6: The cycle after the write strobe rises, chip select is still low and the write byte is still driven. Both are released one cycle later.
- R7: After a read, `mem_dq_oe` stays 0 for at least HZ = ceil(T_HZ_NS/period) cycles after output enable rises. `ready` returns HZ+1 cycles after the read's `done` cycle. After a write, `ready` returns 1 cycle after `done`.
- R8: `ready` is low from the accepting edge until the transaction, including bus turnaround, is complete. A request held high while `ready` is low is not accepted, so each accepted request yields exactly one `done`.
- R9: `done` is high for exactly one cycle per transaction.
- R10: `rdata` keeps the last captured read byte, and writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe, taken when `ready` is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Byte to write |
| ready | output | 1 | Block idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Byte from the latest read |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_o | output | DATA_W | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | DATA_W | Byte returned by the memory |

## Verification
With the default 8 ns period, a read completes 10 cycles after the edge that accepts it and a write also completes 10 cycles after its accepting edge. `ready` comes back 5 cycles after a read's `done` and 1 cycle after a write's `done`. The driver notes the cycle number on the falling edge just before each accepting edge. The monitor takes the cycle number on the falling edge where `done` is seen, so each latency is an exact difference of counters and nothing is read at a clock edge. The memory model also works on falling edges. It counts strobe-low cycles and stable-data cycles against the same nanosecond-derived limits. It returns a corrupted byte until the read window has lasted RC cycles, so a capture made too early is caught by the scoreboard.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_CAP,
        ST_RD_TURN,
        ST_WR_PULSE,
        ST_WR_HOLD
    } seq_st_e;

    // Registered memory-side strobes plus the completion flag
    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic drv;
        logic done;
    } pins_t;

    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period_ns);
        int unsigned c;
        c = (ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

    function automatic pins_t pins_for(seq_st_e s);
        pins_t p;
        p = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0, done: 1'b0};
        case (s)
            ST_RD_ACC:   begin p.ce_n = 1'b0; p.oe_n = 1'b0; end
            ST_RD_CAP:   begin p.done = 1'b1; end
            ST_WR_PULSE: begin p.ce_n = 1'b0; p.we_n = 1'b0; p.drv = 1'b1; end
            ST_WR_HOLD:  begin p.ce_n = 1'b0; p.drv = 1'b1; p.done = 1'b1; end
            default:     ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int RC_CYC = 9,
    parameter int WR_CYC = 9,
    parameter int HZ_CYC = 4,
    parameter int CNT_W  = 5
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  req,
    input  logic  req_we,
    output logic  ready,
    output logic  accept,
    output logic  capture,
    output pins_t pins
);
    localparam logic [CNT_W-1:0] RC_LD = CNT_W'(RC_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LD = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] HZ_LD = CNT_W'(HZ_CYC - 1);

    seq_st_e          st_q, st_nxt;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_zero;
    pins_t            pins_q;

    sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    always_comb begin
        st_nxt = st_q;
        t_load = 1'b0;
        t_val  = '0;
        case (st_q)
            ST_IDLE: begin
                if (req) begin
                    t_load = 1'b1;
                    if (req_we) begin
                        st_nxt = ST_WR_PULSE;
                        t_val  = WR_LD;
                    end else begin
                        st_nxt = ST_RD_ACC;
                        t_val  = RC_LD;
                    end
                end
            end
            ST_RD_ACC:   if (t_zero) st_nxt = ST_RD_CAP;
            ST_RD_CAP: begin
                st_nxt = ST_RD_TURN;
                t_load = 1'b1;
                t_val  = HZ_LD;
            end
            ST_RD_TURN:  if (t_zero) st_nxt = ST_IDLE;
            ST_WR_PULSE: if (t_zero) st_nxt = ST_WR_HOLD;
            ST_WR_HOLD:  st_nxt = ST_IDLE;
            default:     st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            pins_q <= pins_for(ST_IDLE);
        end else begin
            st_q   <= st_nxt;
            pins_q <= pins_for(st_nxt);
        end
    end

    assign ready   = (st_q == ST_IDLE);
    assign accept  = (st_q == ST_IDLE) && req;
    assign capture = (st_q == ST_RD_ACC) && t_zero;
    assign pins    = pins_q;
endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= mem_dq_i;
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_RC_NS       = 70,
    parameter int T_WP_NS       = 40,
    parameter int T_DW_NS       = 40,
    parameter int T_HZ_NS       = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int RC_CYC = int'(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS));
    localparam int WP_CYC = int'(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS));
    localparam int DW_CYC = int'(ns_to_cyc(T_DW_NS, CLK_PERIOD_NS));
    localparam int HZ_CYC = int'(ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS));
    localparam int WR_CYC = int'(max3(RC_CYC, WP_CYC, DW_CYC));
    localparam int CNT_W  = $clog2(int'(max3(RC_CYC, WR_CYC, HZ_CYC)) + 1);

    logic  accept, capture;
    pins_t pins;

    sram_ctrl_seq #(
        .RC_CYC (RC_CYC),
        .WR_CYC (WR_CYC),
        .HZ_CYC (HZ_CYC),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .req_we  (req_we),
        .ready   (ready),
        .accept  (accept),
        .capture (capture),
        .pins    (pins)
    );

    sram_ctrl_dp #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_i  (mem_dq_i),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_o),
        .rdata_q   (rdata)
    );

    assign mem_ce_n  = pins.ce_n;
    assign mem_we_n  = pins.we_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_dq_oe = pins.drv;
    assign done      = pins.done;
endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
    parameter int ADDR_W = 15,
    parameter int HZ_CYC = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              ready,
    input logic              done,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              dq_oe,
    input logic [ADDR_W-1:0] addr
);
    localparam logic [15:0] HZ_LIM = 16'(HZ_CYC);

    // cycles since output enable was last low, saturating at the limit
    logic [15:0] since_oe;
    always_ff @(posedge clk) begin
        if (rst)               since_oe <= HZ_LIM;
        else if (!oe_n)        since_oe <= '0;
        else if (since_oe < HZ_LIM) since_oe <= since_oe + 16'd1;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        ready |-> (ce_n && we_n && oe_n && !dq_oe && !done)); // R1
    AST_READ_STROBES: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (!ce_n && we_n)); // R2
    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (!ce_n && dq_oe)); // R3
    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && $past(!ce_n)) |-> $stable(addr)); // R4
    AST_NO_OE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (oe_n && !ce_n)); // R5
    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> (!ce_n && dq_oe)); // R6
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (since_oe >= HZ_LIM)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
endmodule

bind sram_async_ctrl sram_ctrl_checker #(
    .ADDR_W (ADDR_W),
    .HZ_CYC (HZ_CYC)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .ready (ready),
    .done  (done),
    .ce_n  (mem_ce_n),
    .we_n  (mem_we_n),
    .oe_n  (mem_oe_n),
    .dq_oe (mem_dq_oe),
    .addr  (mem_addr)
);

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/1ps
module sram_async_ctrl_bench;
    localparam int AW = 15;
    localparam int DW = 8;
    localparam int PER = 8;
    localparam int B_RC = (70 + PER - 1) / PER;
    localparam int B_WP = (40 + PER - 1) / PER;
    localparam int B_DS = (40 + PER - 1) / PER;
    localparam int B_HZ = (30 + PER - 1) / PER;
    localparam int B_WR = (B_RC > B_WP) ? ((B_RC > B_DS) ? B_RC : B_DS)
                                        : ((B_WP > B_DS) ? B_WP : B_DS);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic ready, done;
    logic [DW-1:0] rdata;
    logic ce_n, we_n, oe_n, dq_oe;
    logic [AW-1:0] maddr;
    logic [DW-1:0] dq_o;
    logic [DW-1:0] dq_i = '0;

    always #4 clk = ~clk;

    sram_async_ctrl u_sram_async_ctrl (
        .clk (clk), .rst (rst), .req (req), .req_we (req_we),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .ready (ready), .done (done), .rdata (rdata),
        .mem_ce_n (ce_n), .mem_we_n (we_n), .mem_oe_n (oe_n),
        .mem_addr (maddr), .mem_dq_o (dq_o), .mem_dq_oe (dq_oe),
        .mem_dq_i (dq_i)
    );

    int checks = 0;
    int fails = 0;
    longint cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- memory model (falling-edge) ----------------
    logic [DW-1:0] model_mem [int unsigned];
    int rd_age = 0, hold_drv = 0, wlow = 0, dstab = 0;
    logic [AW-1:0] waddr;
    logic [DW-1:0] wdat;

    function automatic logic [DW-1:0] model_rd(input logic [AW-1:0] a);
        if (model_mem.exists(int'(a))) return model_mem[int'(a)];
        return '0;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (!ce_n && we_n && !oe_n) begin
                rd_age++;
                hold_drv = 3;
                dq_i = (rd_age >= B_RC) ? model_rd(maddr) : ~model_rd(maddr);
            end else begin
                rd_age = 0;
                if (hold_drv > 0) hold_drv--;
            end
            if (dq_oe && (hold_drv > 0 || !oe_n))
                check(1'b0, "R7 bus contention", 1, 0);
            if (!ce_n && !we_n) begin
                if (wlow > 0 && maddr != waddr) check(1'b0, "R4 address moved in write", maddr, waddr);
                if (wlow > 0 && dq_o == wdat) dstab++; else dstab = 1;
                if (!dq_oe || !oe_n) check(1'b0, "R5 write without drive", dq_oe, 1);
                wlow++;
                waddr = maddr;
                wdat = dq_o;
            end else if (wlow > 0) begin
                check(wlow >= B_WR, "R3 write pulse cycles", wlow, B_WR);
                check(dstab >= B_DS, "R3 data setup cycles", dstab, B_DS);
                check(!ce_n && dq_oe && dq_o == wdat, "R6 data hold after strobe", dq_o, wdat);
                model_mem[int'(waddr)] = wdat;
                wlow = 0;
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit            is_wr;
        logic [DW-1:0] data;
        longint        acc;
    } item_t;
    item_t sbq[$];
    logic [DW-1:0] sb_mem [int unsigned];
    int pushed = 0, dones = 0;

    task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input int linger);
        item_t it;
        req = 1'b1; req_we = wr; req_addr = a; req_wdata = d;
        while (!ready) @(negedge clk);
        it.is_wr = wr;
        it.acc   = cyc;
        if (wr) begin
            sb_mem[int'(a)] = d;
            it.data = d;
        end else begin
            it.data = sb_mem.exists(int'(a)) ? sb_mem[int'(a)] : '0;
        end
        sbq.push_back(it);
        pushed++;
        @(negedge clk);
        // R8: keep a stale request up while busy; it must not be taken
        for (int k = 0; k < linger; k++) begin
            req_addr = ~a; req_wdata = ~d;
            @(negedge clk);
        end
        req = 1'b0;
    endtask

    longint last_done = 0;
    bit last_rd = 0, ready_prev = 1;
    logic [DW-1:0] last_rdata = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                item_t it;
                dones++;
                if (sbq.size() == 0) begin
                    check(1'b0, "R8 done without request", 1, 0);
                end else begin
                    it = sbq.pop_front();
                    if (it.is_wr) begin
                        check(cyc - it.acc == B_WR + 1, "R3 write latency", cyc - it.acc, B_WR + 1);
                        check(rdata == last_rdata, "R10 rdata held over write", rdata, last_rdata);
                    end else begin
                        check(cyc - it.acc == B_RC + 1, "R2 read latency", cyc - it.acc, B_RC + 1);
                        check(rdata == it.data, "R2 read data", rdata, it.data);
                        last_rdata = rdata;
                    end
                    last_rd = !it.is_wr;
                end
                last_done = cyc;
            end
            if (ready && !ready_prev) begin
                if (last_rd) check(cyc - last_done == B_HZ + 1, "R7 ready after read", cyc - last_done, B_HZ + 1);
                else         check(cyc - last_done == 1, "R7 ready after write", cyc - last_done, 1);
            end
            ready_prev = ready;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(PER * 150000);
        check(1'b0, "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ce_n && we_n && oe_n, "R1 strobes idle after reset", {ce_n, we_n, oe_n}, 3'b111);
        check(!dq_oe && !done && ready, "R1 driver off, ready up", {dq_oe, done, ready}, 3'b001);
        check(rdata == '0, "R10 rdata reset value", rdata, 0);

        do_op(1'b0, 15'h0123, '0, 0);            // R2 unwritten address reads 0
        do_op(1'b1, 15'h0000, 8'h00, 0);
        do_op(1'b1, 15'h7FFF, 8'hFF, 0);
        do_op(1'b1, 15'h1234, 8'hA5, 0);
        do_op(1'b1, 15'h2AAA, 8'h5A, 0);
        do_op(1'b0, 15'h7FFF, '0, 0);
        do_op(1'b0, 15'h0000, '0, 0);            // back-to-back reads
        do_op(1'b0, 15'h1234, '0, 0);
        do_op(1'b1, 15'h1234, 8'h3C, 0);         // read followed by write: turnaround
        do_op(1'b0, 15'h1234, '0, 0);
        do_op(1'b0, 15'h2AAA, '0, 0);
        do_op(1'b1, 15'h0055, 8'hC3, 3);         // R8 stale request while busy
        do_op(1'b0, 15'h0055, '0, 4);
        for (int i = 0; i < 24; i++) begin
            do_op(1'b1, AW'((i * 1237 + 11) & 32'h7FFF), DW'(i * 37 + 1), 0);
            if (i % 3 == 2) do_op(1'b0, AW'(((i - 1) * 1237 + 11) & 32'h7FFF), '0, 0);
        end
        for (int i = 0; i < 24; i += 5)
            do_op(1'b0, AW'((i * 1237 + 11) & 32'h7FFF), '0, 0);

        while (sbq.size() != 0) @(negedge clk);
        repeat (B_HZ + 4) @(negedge clk);
        check(dones == pushed, "R8 one done per accepted request", dones, pushed);
        check(ready && ce_n && we_n && oe_n && !dq_oe, "R1 standby after traffic", {ready, ce_n, we_n, oe_n, dq_oe}, 5'b11110);
        finish_run();
    end
endmodule